// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block arbitrates among eight interrupt request lines. It keeps three registers of one bit per line: pending requests, lines in service and masked lines. A separate trigger-mode input chooses, line by line, between edge capture and level following. The winner is chosen against a rotating priority base: the line equal to the base ranks first and the ranking wraps upward from there. A single interrupt output is raised when the best unmasked pending line ranks strictly above the best line counted as in service.

The winner index appears combinationally next to the interrupt output, which doubles as its valid flag, so an acknowledge or poll path can take it in the same cycle. An acknowledge strobe either places the winner in service or, with automatic end-of-interrupt enabled, leaves the service register alone and can rotate the base past the winner. The mode bits arrive as static inputs: special masking, nested handling of the cascade line on a master, automatic end-of-interrupt and rotation on it. The mask register, the base and clears of single service bits are loaded through plain strobes. Bus decoding and cascading belong to the surrounding logic.

Top module: `rot_prio_resolver`

## Requirements
- R1: A synchronous reset clears the request, service, mask and last-level registers and sets the base to 0, so `int_out` is low after reset.
- R2: The rank of line n is (n - base) mod 8, 0 being best. `win_idx` gives the best-ranked line among pending, unmasked lines. `base_we` loads `base_wdata` into the base and takes precedence over rotation.
- R3: Lines whose `mask_bits` bit is 1 are not candidates. `int_out` is 1 only when the best candidate ranks strictly better than the best counted service line; an empty set ranks 8.
- R4: With `cfg_special_mask` set, service bits of masked lines are not counted when the current service rank is found.
- R5: With both `cfg_nested` and `cfg_master` set, service bit 2 (the cascade line) is not counted.
- R6: For a line with `trig_level` bit 0 (edge), a request bit is set only when the input is 1 and was 0 in the previous cycle. A held-high or falling input does not set it.
- R7: For a line with `trig_level` bit 1 (level), the request bit follows the input one cycle later, in both directions.
- R8: An acknowledge with `int_out` high and `cfg_auto_eoi` low sets the winner's service bit.
- R9: With `cfg_auto_eoi` high, an acknowledge leaves the service register unchanged. If `cfg_rotate_aeoi` is also high, the base becomes (winner + 1) mod 8; otherwise it is unchanged.
- R10: An acknowledge clears the winner's request bit only for an edge line. A level line's request bit stays set while its input is high.
- R11: `isr_clr` clears the service bit selected by `isr_clr_idx`. If a set and a clear hit the same bit in the same cycle, the set wins.
- R12: An acknowledge while `int_out` is low changes neither the request, service nor base registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Request lines, synchronous to clk |
| trig_level | input | 8 | Per-line mode: 1 level, 0 edge |
| mask_we | input | 1 | Load the mask register |
| mask_wdata | input | 8 | New mask value, 1 masks a line |
| base_we | input | 1 | Load the priority base |
| base_wdata | input | 3 | New priority base |
| isr_clr | input | 1 | Clear one service bit |
| isr_clr_idx | input | 3 | Service bit to clear |
| ack | input | 1 | Acknowledge strobe |
| cfg_special_mask | input | 1 | Ignore masked lines when ranking service |
| cfg_nested | input | 1 | Nested handling of the cascade line |
| cfg_master | input | 1 | This unit is the master |
| cfg_auto_eoi | input | 1 | Automatic end-of-interrupt on acknowledge |
| cfg_rotate_aeoi | input | 1 | Rotate the base on automatic end-of-interrupt |
| int_out | output | 1 | Interrupt request, also winner-valid |
| win_idx | output | 3 | Winning line, meaningful when int_out is 1 |
| req_bits | output | 8 | Request register |
| svc_bits | output | 8 | Service register |
| mask_bits | output | 8 | Mask register |
| base_out | output | 3 | Current priority base |

## Verification
The assertions take the request lines as already synchronous to the clock and sampled once per cycle. They also expect the reset to be held from time zero through the first edges, and they leave out cycles where a service clear or a base load meets an acknowledge on the same state. The stimulus changes inputs only between edges and never drives such same-cycle collisions. A behavioural reference model runs in parallel, and directed sequences target equal-rank blocking, mask and nesting exclusions, rotation and idle acknowledges.

// File: rtl/rpir_pkg.sv
package rpir_pkg;
    typedef struct packed {
        logic special_mask;
        logic nested;
        logic master;
        logic auto_eoi;
        logic rotate_aeoi;
    } rpir_cfg_t;
endpackage

// File: rtl/rot_pick.sv
module rot_pick #(
    parameter int N = 8,
    localparam int IW = $clog2(N),
    localparam int LW = $clog2(N + 1)
) (
    input  logic [N-1:0]  mask,
    input  logic [IW-1:0] base,
    output logic [LW-1:0] lvl
);
    logic [IW-1:0] slot;

    always_comb begin
        lvl  = LW'(N);
        slot = '0;
        for (int p = N - 1; p >= 0; p--) begin
            slot = base + IW'(p);
            if (mask[slot]) begin
                lvl = LW'(p);
            end
        end
    end
endmodule

// File: rtl/req_capture.sv
module req_capture #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] trig_level,
    input  logic [N-1:0] edge_clr,
    output logic [N-1:0] irr_q
);
    logic [N-1:0] last_q;
    logic [N-1:0] irr_d;

    for (genvar i = 0; i < N; i++) begin : g_line
        assign irr_d[i] = trig_level[i] ? irq_in[i]
                        : (irq_in[i] && !last_q[i]) ? 1'b1
                        : edge_clr[i] ? 1'b0
                        : irr_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irr_q  <= '0;
            last_q <= '0;
        end else begin
            irr_q  <= irr_d;
            last_q <= irq_in;
        end
    end

    property p_edge_needs_rise;
        @(posedge clk) disable iff (rst)
        !$past(rst) |-> (irr_q & ~$past(irr_q) & ~$past(trig_level)
                         & ~($past(irq_in) & ~$past(last_q))) == '0;
    endproperty
    assert_edge_set_on_rise_R6: assert property (p_edge_needs_rise);

    property p_level_follows;
        @(posedge clk) disable iff (rst)
        !$past(rst) |-> ((irr_q ^ $past(irq_in)) & $past(trig_level)) == '0;
    endproperty
    assert_level_follows_R7: assert property (p_level_follows);
endmodule

// File: rtl/svc_track.sv
module svc_track #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] isr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q <= '0;
        end else begin
            isr_q <= (isr_q & ~clr_vec) | set_vec;
        end
    end
endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver
    import rpir_pkg::*;
#(
    parameter int N = 8,
    parameter int CASC_LINE = 2,
    localparam int IW = $clog2(N),
    localparam int LW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  irq_in,
    input  logic [N-1:0]  trig_level,
    input  logic          mask_we,
    input  logic [N-1:0]  mask_wdata,
    input  logic          base_we,
    input  logic [IW-1:0] base_wdata,
    input  logic          isr_clr,
    input  logic [IW-1:0] isr_clr_idx,
    input  logic          ack,
    input  logic          cfg_special_mask,
    input  logic          cfg_nested,
    input  logic          cfg_master,
    input  logic          cfg_auto_eoi,
    input  logic          cfg_rotate_aeoi,
    output logic          int_out,
    output logic [IW-1:0] win_idx,
    output logic [N-1:0]  req_bits,
    output logic [N-1:0]  svc_bits,
    output logic [N-1:0]  mask_bits,
    output logic [IW-1:0] base_out
);
    rpir_cfg_t     cfg;
    logic [N-1:0]  irr_q;
    logic [N-1:0]  isr_q;
    logic [N-1:0]  imr_q;
    logic [IW-1:0] base_q;
    logic [N-1:0]  cand;
    logic [N-1:0]  excl;
    logic [N-1:0]  svc_view;
    logic [LW-1:0] cand_lvl;
    logic [LW-1:0] svc_lvl;
    logic          fire;
    logic          take;
    logic [N-1:0]  win_onehot;
    logic [N-1:0]  edge_clr;
    logic [N-1:0]  set_vec;
    logic [N-1:0]  clr_vec;

    assign cfg = '{special_mask: cfg_special_mask, nested: cfg_nested,
                   master: cfg_master, auto_eoi: cfg_auto_eoi,
                   rotate_aeoi: cfg_rotate_aeoi};

    always_comb begin
        cand     = irr_q & ~imr_q;
        excl     = (cfg.nested && cfg.master) ? (N'(1) << CASC_LINE) : '0;
        svc_view = isr_q & ~excl;
        if (cfg.special_mask) begin
            svc_view = svc_view & ~imr_q;
        end
    end

    rot_pick #(.N(N)) u_cand_pick (.mask(cand),     .base(base_q), .lvl(cand_lvl));
    rot_pick #(.N(N)) u_svc_pick  (.mask(svc_view), .base(base_q), .lvl(svc_lvl));

    always_comb begin
        fire       = (cand_lvl < svc_lvl);
        win_idx    = base_q + cand_lvl[IW-1:0];
        take       = ack && fire;
        win_onehot = N'(1) << win_idx;
        edge_clr   = take ? win_onehot : '0;
        set_vec    = (take && !cfg.auto_eoi) ? win_onehot : '0;
        clr_vec    = isr_clr ? (N'(1) << isr_clr_idx) : '0;
    end

    req_capture #(.N(N)) u_req (
        .clk        (clk),
        .rst        (rst),
        .irq_in     (irq_in),
        .trig_level (trig_level),
        .edge_clr   (edge_clr),
        .irr_q      (irr_q)
    );

    svc_track #(.N(N)) u_svc (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .isr_q   (isr_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            imr_q  <= '0;
            base_q <= '0;
        end else begin
            if (mask_we) begin
                imr_q <= mask_wdata;
            end
            if (base_we) begin
                base_q <= base_wdata;
            end else if (take && cfg.auto_eoi && cfg.rotate_aeoi) begin
                base_q <= win_idx + 1'b1;
            end
        end
    end

    assign int_out   = fire;
    assign req_bits  = irr_q;
    assign svc_bits  = isr_q;
    assign mask_bits = imr_q;
    assign base_out  = base_q;

    property p_winner_pending;
        @(posedge clk) disable iff (rst)
        int_out |-> (req_bits[win_idx] && !mask_bits[win_idx]);
    endproperty
    assert_winner_is_candidate_R2: assert property (p_winner_pending);

    property p_ack_marks;
        @(posedge clk) disable iff (rst)
        (ack && int_out && !cfg_auto_eoi) |=> svc_bits[$past(win_idx)];
    endproperty
    assert_ack_marks_service_R8: assert property (p_ack_marks);

    property p_aeoi_rotate;
        @(posedge clk) disable iff (rst)
        (ack && int_out && cfg_auto_eoi && cfg_rotate_aeoi && !base_we)
            |=> base_out == IW'($past(win_idx) + 1'b1);
    endproperty
    assert_aeoi_rotates_R9: assert property (p_aeoi_rotate);

    property p_aeoi_keeps_svc;
        @(posedge clk) disable iff (rst)
        (ack && cfg_auto_eoi && !isr_clr) |=> $stable(svc_bits);
    endproperty
    assert_aeoi_keeps_service_R9: assert property (p_aeoi_keeps_svc);

    property p_idle_ack;
        @(posedge clk) disable iff (rst)
        (ack && !int_out && !isr_clr) |=> $stable(svc_bits);
    endproperty
    assert_idle_ack_no_effect_R12: assert property (p_idle_ack);
endmodule

// File: tb/sim_rot_prio_resolver.sv
module sim_rot_prio_resolver;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_in = '0, trig_level = '0, mask_wdata = '0;
    logic       mask_we = 0, base_we = 0, isr_clr = 0, ack = 0;
    logic [2:0] base_wdata = '0, isr_clr_idx = '0;
    logic       cfg_special_mask = 0, cfg_nested = 0, cfg_master = 0;
    logic       cfg_auto_eoi = 0, cfg_rotate_aeoi = 0;
    logic       int_out;
    logic [2:0] win_idx, base_out;
    logic [7:0] req_bits, svc_bits, mask_bits;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    bit [7:0] m_irr = 0, m_isr = 0, m_imr = 0, m_last = 0;
    int       m_base = 0;

    always #2 clk = ~clk;

    rot_prio_resolver u0 (
        .clk(clk), .rst(rst), .irq_in(irq_in), .trig_level(trig_level),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .base_we(base_we),
        .base_wdata(base_wdata), .isr_clr(isr_clr), .isr_clr_idx(isr_clr_idx),
        .ack(ack), .cfg_special_mask(cfg_special_mask), .cfg_nested(cfg_nested),
        .cfg_master(cfg_master), .cfg_auto_eoi(cfg_auto_eoi),
        .cfg_rotate_aeoi(cfg_rotate_aeoi), .int_out(int_out), .win_idx(win_idx),
        .req_bits(req_bits), .svc_bits(svc_bits), .mask_bits(mask_bits),
        .base_out(base_out)
    );

    function automatic int rank_of(bit [7:0] m, int b);
        for (int p = 0; p < 8; p++) begin
            if (m[(p + b) % 8]) return p;
        end
        return 8;
    endfunction

    function automatic bit exp_fire();
        bit [7:0] s;
        s = m_isr;
        if (cfg_special_mask) s = s & ~m_imr;
        if (cfg_nested && cfg_master) s[2] = 1'b0;
        return rank_of(m_irr & ~m_imr, m_base) < rank_of(s, m_base);
    endfunction

    function automatic int exp_win();
        return (rank_of(m_irr & ~m_imr, m_base) + m_base) % 8;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        bit f;
        int w;
        bit [7:0] n_irr;
        if (rst) begin
            m_irr = 0; m_isr = 0; m_imr = 0; m_last = 0; m_base = 0;
            return;
        end
        f = exp_fire() && ack;
        w = exp_win();
        n_irr = m_irr;
        for (int i = 0; i < 8; i++) begin
            if (trig_level[i]) n_irr[i] = irq_in[i];
            else if (irq_in[i] && !m_last[i]) n_irr[i] = 1'b1;
            else if (f && w == i) n_irr[i] = 1'b0;
        end
        if (isr_clr) m_isr[isr_clr_idx] = 1'b0;
        if (f && !cfg_auto_eoi) m_isr[w] = 1'b1;
        if (base_we) m_base = base_wdata;
        else if (f && cfg_auto_eoi && cfg_rotate_aeoi) m_base = (w + 1) % 8;
        if (mask_we) m_imr = mask_wdata;
        m_irr = n_irr;
        m_last = irq_in;
    endtask

    task automatic model_compare();
        chk("R3 model int_out", int_out, exp_fire());
        if (exp_fire()) chk("R2 model win_idx", win_idx, exp_win());
        chk("R6 model req_bits", req_bits, m_irr);
        chk("R8 model svc_bits", svc_bits, m_isr);
        chk("R9 model base_out", base_out, m_base);
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        #1;
        model_compare();
    endtask

    task automatic idle();
        irq_in = 0; trig_level = 0; mask_we = 0; mask_wdata = 0;
        base_we = 0; base_wdata = 0; isr_clr = 0; isr_clr_idx = 0; ack = 0;
        cfg_special_mask = 0; cfg_nested = 0; cfg_master = 0;
        cfg_auto_eoi = 0; cfg_rotate_aeoi = 0;
    endtask

    task automatic do_reset();
        rst = 1; idle();
        cyc(); cyc();
        rst = 0;
        cyc();
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle();
        do_reset();
        // R1 reset state
        chk("R1 int_out", int_out, 0);
        chk("R1 req_bits", req_bits, 0);
        chk("R1 svc_bits", svc_bits, 0);
        chk("R1 mask_bits", mask_bits, 0);
        chk("R1 base_out", base_out, 0);

        // Edge capture, acknowledge, equal-rank blocking
        irq_in = 8'h20; cyc();
        chk("R6 rise sets", req_bits, 8'h20);
        chk("R2 win base0", win_idx, 5);
        chk("R3 int raised", int_out, 1);
        cyc();
        chk("R6 held high", req_bits, 8'h20);
        ack = 1; cyc(); ack = 0;
        chk("R8 svc set", svc_bits, 8'h20);
        chk("R10 edge cleared", req_bits, 0);
        cyc();
        chk("R6 no retrigger", req_bits, 0);
        irq_in = 0; cyc();
        irq_in = 8'h20; cyc();
        chk("R6 second rise", req_bits, 8'h20);
        chk("R3 equal rank blocked", int_out, 0);
        ack = 1; cyc(); ack = 0;
        chk("R12 svc unchanged", svc_bits, 8'h20);
        chk("R12 req unchanged", req_bits, 8'h20);
        isr_clr = 1; isr_clr_idx = 5; cyc(); isr_clr = 0;
        chk("R11 svc cleared", svc_bits, 0);
        chk("R11 int returns", int_out, 1);

        // Level mode
        do_reset();
        trig_level = 8'h08; irq_in = 8'h28; cyc();
        chk("R7 level set", req_bits, 8'h28);
        chk("R2 win 3", win_idx, 3);
        ack = 1; cyc(); ack = 0;
        chk("R8 svc 3", svc_bits, 8'h08);
        chk("R10 level kept", req_bits, 8'h28);
        chk("R3 lower blocked", int_out, 0);
        irq_in = 8'h20; cyc();
        chk("R7 level falls", req_bits, 8'h20);

        // Rotation through base load and masking
        do_reset();
        irq_in = 8'h22; base_we = 1; base_wdata = 6; cyc(); base_we = 0;
        chk("R2 base load", base_out, 6);
        chk("R2 win base6", win_idx, 1);
        base_we = 1; base_wdata = 2; cyc(); base_we = 0;
        chk("R2 win base2", win_idx, 5);
        mask_we = 1; mask_wdata = 8'h20; cyc(); mask_we = 0;
        chk("R3 masked line skipped", win_idx, 1);
        chk("R3 mask reg", mask_bits, 8'h20);

        // Special mask
        do_reset();
        irq_in = 8'h02; cyc();
        ack = 1; cyc(); ack = 0;
        irq_in = 8'h22; cyc();
        chk("R3 higher in service", int_out, 0);
        mask_we = 1; mask_wdata = 8'h02; cyc(); mask_we = 0;
        chk("R4 special off", int_out, 0);
        cfg_special_mask = 1; cyc();
        chk("R4 special on int", int_out, 1);
        chk("R4 special on win", win_idx, 5);

        // Nested cascade exclusion
        do_reset();
        irq_in = 8'h04; cyc();
        ack = 1; cyc(); ack = 0;
        irq_in = 0; cyc();
        irq_in = 8'h04; cyc();
        chk("R5 nested off", int_out, 0);
        cfg_nested = 1; cfg_master = 1; cyc();
        chk("R5 nested master int", int_out, 1);
        chk("R5 nested master win", win_idx, 2);
        cfg_master = 0; cyc();
        chk("R5 not master", int_out, 0);

        // Automatic end-of-interrupt
        do_reset();
        cfg_auto_eoi = 1; cfg_rotate_aeoi = 1;
        irq_in = 8'h08; cyc();
        ack = 1; cyc(); ack = 0;
        chk("R9 svc untouched", svc_bits, 0);
        chk("R9 base rotated", base_out, 4);
        chk("R10 edge cleared aeoi", req_bits, 0);
        cfg_rotate_aeoi = 0;
        irq_in = 8'h48; cyc();
        ack = 1; cyc(); ack = 0;
        chk("R9 no rotate", base_out, 4);
        chk("R9 svc still empty", svc_bits, 0);
        irq_in = 8'h6c; cyc();
        chk("R6 new rises only", req_bits, 8'h24);
        chk("R2 win base4", win_idx, 5);

        // Acknowledge with nothing pending
        do_reset();
        ack = 1; cyc(); ack = 0;
        chk("R12 idle svc", svc_bits, 0);
        chk("R12 idle base", base_out, 0);
        chk("R12 idle req", req_bits, 0);
        cyc();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule